// File: doc/BRIEF.md
# Selectable Lossless Color Transform

This block converts pixels between RGB and a luma/chroma representation without losing any information, in either direction. One pixel enters per cycle, qualified by a valid strobe. A two-bit mode input picks the transform for that pixel. The three choices are a plain green-difference transform, an integer reversible transform with a weighted luma, and a lifting transform with orange and green chroma. A direction input picks forward (RGB to luma/chroma) or inverse (luma/chroma to RGB). Mode and direction may change from one pixel to the next.

Components are 8 bits wide (parameter `PIX_W`). The luma/red channel is always `PIX_W` bits wide. The two chroma/green/blue channels are `PIX_W+1` bits wide, so that the signed chroma of the weighted and lifting transforms fits. In the difference mode the chroma wraps modulo 2^PIX_W and its top bit is zero. Every path is padded to the same two-stage pipeline, so results leave in input order at a fixed latency. An encoder and a decoder can therefore share one instance, or the block can sit inline in a pixel stream.

Channel order: forward inputs are R on `in_c0`, G on `in_c1` and B on `in_c2`. Forward outputs are luma on `out_c0`, blue chroma on `out_c1` and red chroma on `out_c2`. The inverse direction takes those three values on the same input ports and returns R, G and B on `out_c0`, `out_c1` and `out_c2`.

Top module: `color_xform`

## Requirements
- R1: While `rst` is high, and on the first edge after it rises, `out_valid` is low, and pixels already in the pipeline are dropped.
- R2: A pixel accepted with `in_valid` high at a clock edge appears with `out_valid` high exactly two edges later, whatever its mode and direction, including when mode and direction change on every pixel.
- R3: A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later, and its input data has no effect on any output.
- R4: Mode 0, forward: `out_c0`=G, `out_c1`={0,(B-G) mod 256}, `out_c2`={0,(R-G) mod 256}.
- R5: Mode 0, inverse: with Y, Cb, Cr on the inputs, the outputs are R=(Cr+Y) mod 256, G=Y and B=(Cb+Y) mod 256, so every forward result is restored exactly.
- R6: Mode 1, forward: `out_c0`=floor((R+2G+B)/4), `out_c1`=B-G and `out_c2`=R-G, both as 9-bit two's complement.
- R7: Mode 1, inverse: G=Y-floor((Cb+Cr)/4), R=Cr+G and B=Cb+G, with the chroma read as 9-bit signed values; this exactly restores every RGB input of R6.
- R8: Mode 2, forward: Co=B-R, t=R+floor(Co/2), Cg=t-G and Y=G+floor(Cg/2). The outputs are `out_c0`=Y, with Co on `out_c1` and Cg on `out_c2` as 9-bit two's complement.
- R9: Mode 2, inverse: G=Y-floor(Cg/2), t=Cg+G, R=t-floor(Co/2) and B=Co+R; this exactly restores every RGB input of R8.
- R10: Mode code 3 behaves exactly as mode 0 in both directions.
- R11: Bit 8 of `in_c1` and `in_c2` is ignored in the forward direction of every mode and in both directions of mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel on the inputs is to be converted |
| in_mode | input | 2 | Transform select: 0 difference, 1 weighted reversible, 2 lifting, 3 as 0 |
| in_inv | input | 1 | 0 forward (RGB in), 1 inverse (luma/chroma in) |
| in_c0 | input | PIX_W | R (forward) or luma (inverse) |
| in_c1 | input | PIX_W+1 | G (forward) or blue/orange chroma (inverse) |
| in_c2 | input | PIX_W+1 | B (forward) or red/green chroma (inverse) |
| out_valid | output | 1 | Output pixel is valid |
| out_c0 | output | PIX_W | Luma (forward) or R (inverse) |
| out_c1 | output | PIX_W+1 | Blue/orange chroma (forward) or G (inverse) |
| out_c2 | output | PIX_W+1 | Red/green chroma (forward) or B (inverse) |

## Verification
On every cycle the assertions check the reset flush, the two-edge valid latency, the bubble passing through unchanged, and the difference-mode luma and zero top bits. They also recompute the weighted luma and the weighted-mode inverse green from the inputs two edges earlier. Exact restoration needs a matched forward/inverse pair of pixels, so only the bench scenarios show it. The bench sends each forward result back through the inverse path over a grid of RGB values and the extreme corners. The scenarios also cover the wrap and floor corners, the spare mode code, the ignored top input bits, and mode changes on every cycle.

// File: rtl/color_xform_pkg.sv
`timescale 1ns/1ps
package color_xform_pkg;

  // Transform selection codes carried on in_mode
  typedef enum logic [1:0] {
    XF_DIFF  = 2'd0,
    XF_RCT   = 2'd1,
    XF_LIFT  = 2'd2,
    XF_SPARE = 2'd3
  } xf_mode_e;

  // Number of transform kernels running in parallel
  localparam int NUM_KERNELS = 3;

  // Pipeline depth shared by every mode and direction
  localparam int PIPE_DEPTH = 2;

endpackage

// File: rtl/cx_diff_stage.sv
`timescale 1ns/1ps
// Green-difference kernel: modular arithmetic, result complete after stage 1
module cx_diff_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             inv,
  input  logic [PIX_W-1:0] a0,
  input  logic [PIX_W-1:0] a1,
  input  logic [PIX_W-1:0] a2,
  output logic [PIX_W-1:0] q0,
  output logic [PIX_W:0]   q1,
  output logic [PIX_W:0]   q2
);

  logic [PIX_W-1:0] d0, d1, d2;

  always_ff @(posedge clk) begin
    if (en) begin
      if (!inv) begin
        d0 <= a1;            // luma is green
        d1 <= a2 - a1;       // blue minus green, wraps
        d2 <= a0 - a1;       // red minus green, wraps
      end else begin
        d0 <= a2 + a0;       // red back
        d1 <= a0;            // green back
        d2 <= a1 + a0;       // blue back
      end
    end
  end

  assign q0 = d0;
  assign q1 = {1'b0, d1};
  assign q2 = {1'b0, d2};

endmodule

// File: rtl/cx_rct_stage.sv
`timescale 1ns/1ps
// Weighted reversible kernel: forward done in stage 1, inverse split over two
module cx_rct_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             inv,
  input  logic             inv_s,
  input  logic [PIX_W-1:0] a0,
  input  logic [PIX_W:0]   a1,
  input  logic [PIX_W:0]   a2,
  output logic [PIX_W-1:0] q0,
  output logic [PIX_W:0]   q1,
  output logic [PIX_W:0]   q2
);

  localparam int CW = PIX_W + 1;
  localparam int W  = PIX_W + 3;

  function automatic logic signed [W-1:0] zx(input logic [PIX_W-1:0] v);
    return $signed({{(W-PIX_W){1'b0}}, v});
  endfunction

  function automatic logic signed [W-1:0] sx(input logic [CW-1:0] v);
    return $signed({{(W-CW){v[CW-1]}}, v});
  endfunction

  logic signed [CW-1:0] s0, s1, s2;

  always_ff @(posedge clk) begin
    if (en) begin
      if (!inv) begin
        s0 <= CW'((zx(a0) + (zx(a1[PIX_W-1:0]) <<< 1) + zx(a2[PIX_W-1:0])) >>> 2);
        s1 <= CW'(zx(a2[PIX_W-1:0]) - zx(a1[PIX_W-1:0]));
        s2 <= CW'(zx(a0) - zx(a1[PIX_W-1:0]));
      end else begin
        s0 <= CW'(zx(a0) - ((sx(a1) + sx(a2)) >>> 2));
        s1 <= $signed(a1);
        s2 <= $signed(a2);
      end
    end
  end

  always_comb begin
    if (!inv_s) begin
      q0 = PIX_W'(s0);
      q1 = s1;
      q2 = s2;
    end else begin
      q0 = PIX_W'(s2 + s0);
      q1 = {1'b0, PIX_W'(s0)};
      q2 = {1'b0, PIX_W'(s1 + s0)};
    end
  end

endmodule

// File: rtl/cx_lift_stage.sv
`timescale 1ns/1ps
// Lifting kernel: two lifting steps per stage in both directions
module cx_lift_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             inv,
  input  logic             inv_s,
  input  logic [PIX_W-1:0] a0,
  input  logic [PIX_W:0]   a1,
  input  logic [PIX_W:0]   a2,
  output logic [PIX_W-1:0] q0,
  output logic [PIX_W:0]   q1,
  output logic [PIX_W:0]   q2
);

  localparam int CW = PIX_W + 1;
  localparam int W  = PIX_W + 3;

  function automatic logic signed [W-1:0] zx(input logic [PIX_W-1:0] v);
    return $signed({{(W-PIX_W){1'b0}}, v});
  endfunction

  function automatic logic signed [W-1:0] sx(input logic [CW-1:0] v);
    return $signed({{(W-CW){v[CW-1]}}, v});
  endfunction

  logic signed [W-1:0]  diff1, mid1;
  logic signed [CW-1:0] n0, n1, n2;
  logic signed [CW-1:0] s0, s1, s2;
  logic signed [W-1:0]  diff2, sum2;

  // stage 1: first two lifting steps
  always_comb begin
    if (!inv) begin
      diff1 = zx(a2[PIX_W-1:0]) - zx(a0);          // orange chroma
      mid1  = zx(a0) + (diff1 >>> 1);             // temporary
      n0    = CW'(diff1);
      n1    = CW'(mid1);
      n2    = CW'(zx(a1[PIX_W-1:0]));             // green carried
    end else begin
      diff1 = zx(a0) - (sx(a2) >>> 1);            // green restored
      mid1  = sx(a2) + diff1;                     // temporary restored
      n0    = CW'(diff1);
      n1    = CW'(mid1);
      n2    = $signed(a1);                        // orange chroma carried
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s0 <= n0;
      s1 <= n1;
      s2 <= n2;
    end
  end

  // stage 2: last two lifting steps
  always_comb begin
    if (!inv_s) begin
      diff2 = sx(s1) - sx(s2);                    // green chroma
      sum2  = sx(s2) + (diff2 >>> 1);             // luma
      q0    = PIX_W'(sum2);
      q1    = s0;
      q2    = CW'(diff2);
    end else begin
      diff2 = sx(s1) - (sx(s2) >>> 1);            // red
      sum2  = sx(s2) + diff2;                     // blue
      q0    = PIX_W'(diff2);
      q1    = {1'b0, PIX_W'(s0)};
      q2    = {1'b0, PIX_W'(sum2)};
    end
  end

endmodule

// File: rtl/color_xform.sv
`timescale 1ns/1ps
module color_xform
  import color_xform_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic             in_inv,
  input  logic [PIX_W-1:0] in_c0,
  input  logic [PIX_W:0]   in_c1,
  input  logic [PIX_W:0]   in_c2,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_c0,
  output logic [PIX_W:0]   out_c1,
  output logic [PIX_W:0]   out_c2
);

  localparam int CW = PIX_W + 1;

  // stage-1 control
  logic       v1;
  logic [1:0] mode1;
  logic       inv1;

  // kernel results, one slot per kernel
  logic [PIX_W-1:0] kq0 [NUM_KERNELS];
  logic [CW-1:0]    kq1 [NUM_KERNELS];
  logic [CW-1:0]    kq2 [NUM_KERNELS];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      mode1 <= in_mode;
      inv1  <= in_inv;
    end
  end

  cx_diff_stage #(.PIX_W(PIX_W)) u_diff (
    .clk (clk),
    .en  (in_valid),
    .inv (in_inv),
    .a0  (in_c0),
    .a1  (in_c1[PIX_W-1:0]),
    .a2  (in_c2[PIX_W-1:0]),
    .q0  (kq0[0]),
    .q1  (kq1[0]),
    .q2  (kq2[0])
  );

  cx_rct_stage #(.PIX_W(PIX_W)) u_rct (
    .clk   (clk),
    .en    (in_valid),
    .inv   (in_inv),
    .inv_s (inv1),
    .a0    (in_c0),
    .a1    (in_c1),
    .a2    (in_c2),
    .q0    (kq0[1]),
    .q1    (kq1[1]),
    .q2    (kq2[1])
  );

  cx_lift_stage #(.PIX_W(PIX_W)) u_lift (
    .clk   (clk),
    .en    (in_valid),
    .inv   (in_inv),
    .inv_s (inv1),
    .a0    (in_c0),
    .a1    (in_c1),
    .a2    (in_c2),
    .q0    (kq0[2]),
    .q1    (kq1[2]),
    .q2    (kq2[2])
  );

  // stage 2: kernel select and output registers
  logic [PIX_W-1:0] sel0;
  logic [CW-1:0]    sel1, sel2;

  always_comb begin
    case (mode1)
      XF_RCT: begin
        sel0 = kq0[1]; sel1 = kq1[1]; sel2 = kq2[1];
      end
      XF_LIFT: begin
        sel0 = kq0[2]; sel1 = kq1[2]; sel2 = kq2[2];
      end
      default: begin
        sel0 = kq0[0]; sel1 = kq1[0]; sel2 = kq2[0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (v1) begin
      out_c0 <= sel0;
      out_c1 <= sel1;
      out_c2 <= sel2;
    end
  end

endmodule

// File: rtl/color_xform_chk.sv
`timescale 1ns/1ps
module color_xform_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       in_mode,
  input logic             in_inv,
  input logic [PIX_W-1:0] in_c0,
  input logic [PIX_W:0]   in_c1,
  input logic [PIX_W:0]   in_c2,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_c0,
  input logic [PIX_W:0]   out_c1,
  input logic [PIX_W:0]   out_c2
);

  localparam int CW = PIX_W + 1;
  localparam int W  = PIX_W + 3;

  // two-deep history of the inputs
  logic [1:0]       m1, m2;
  logic             i1, i2;
  logic [PIX_W-1:0] h1c0, h2c0;
  logic [CW-1:0]    h1c1, h2c1, h1c2, h2c2;

  always_ff @(posedge clk) begin
    m1 <= in_mode; i1 <= in_inv; h1c0 <= in_c0; h1c1 <= in_c1; h1c2 <= in_c2;
    m2 <= m1;      i2 <= i1;     h2c0 <= h1c0;  h2c1 <= h1c1;  h2c2 <= h1c2;
  end

  logic [PIX_W+1:0]    luma_sum;
  logic signed [W-1:0] g_back;

  assign luma_sum = {2'b00, h2c0} + {1'b0, h2c1[PIX_W-1:0], 1'b0} + {2'b00, h2c2[PIX_W-1:0]};
  assign g_back   = $signed({{(W-PIX_W){1'b0}}, h2c0})
                  - (($signed({{(W-CW){h2c1[CW-1]}}, h2c1})
                    + $signed({{(W-CW){h2c2[CW-1]}}, h2c2})) >>> 2);

  // R1
  reset_flush_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R3
  bubble_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R4
  diff_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && m2 == 2'd0 && !i2) |->
      (out_c0 == h2c1[PIX_W-1:0] && !out_c1[PIX_W] && !out_c2[PIX_W]));

  // R6
  rct_luma_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && m2 == 2'd1 && !i2) |-> (out_c0 == luma_sum[PIX_W+1:2]));

  // R7
  rct_green_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && m2 == 2'd1 && i2) |-> (out_c1 == {1'b0, PIX_W'(g_back)}));

endmodule

bind color_xform color_xform_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/color_xform_bench.sv
`timescale 1ns/1ps
module color_xform_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_mode = 2'd0;
  logic       in_inv = 1'b0;
  logic [7:0] in_c0 = '0;
  logic [8:0] in_c1 = '0;
  logic [8:0] in_c2 = '0;
  logic       out_valid;
  logic [7:0] out_c0;
  logic [8:0] out_c1, out_c2;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  color_xform #(.PIX_W(8)) u_color_xform (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode), .in_inv(in_inv),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  typedef struct {
    bit         vld;
    logic [7:0] e0;
    logic [8:0] e1;
    logic [8:0] e2;
    int         issue;
    string      tag;
  } exp_t;

  exp_t expq[$];

  // independent forward model: returns luma and both chroma
  function automatic void model(input int m, input int r, input int g, input int b,
                                output logic [7:0] y, output logic [8:0] c1, output logic [8:0] c2);
    int co, t, cg;
    case (m)
      1: begin
        y  = 8'((r + 2*g + b) / 4);
        c1 = 9'(b - g);
        c2 = 9'(r - g);
      end
      2: begin
        co = b - r;
        t  = r + (co >>> 1);
        cg = t - g;
        y  = 8'(g + (cg >>> 1));
        c1 = 9'(co);
        c2 = 9'(cg);
      end
      default: begin
        y  = 8'(g);
        c1 = {1'b0, 8'(b - g)};
        c2 = {1'b0, 8'(r - g)};
      end
    endcase
  endfunction

  task automatic drive(input bit v, input logic [1:0] m, input bit inv,
                       input logic [7:0] a0, input logic [8:0] a1, input logic [8:0] a2,
                       input logic [7:0] e0, input logic [8:0] e1, input logic [8:0] e2,
                       input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_mode = m; in_inv = inv;
    in_c0 = a0; in_c1 = a1; in_c2 = a2;
    e.vld = v; e.e0 = e0; e.e1 = e1; e.e2 = e2; e.issue = cyc; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic bubble(input logic [7:0] junk);
    drive(1'b0, 2'(junk), junk[0], junk, {junk[0], ~junk}, {1'b1, junk}, '0, '0, '0, "R3 bubble");
  endtask

  // forward pixel, then its forward result through the inverse path
  task automatic round_trip(input int m, input int r, input int g, input int b,
                            input string tf, input string ti);
    logic [7:0] y;
    logic [8:0] c1, c2;
    model(m, r, g, b, y, c1, c2);
    drive(1'b1, 2'(m), 1'b0, 8'(r), 9'(g), 9'(b), y, c1, c2, tf);
    drive(1'b1, 2'(m), 1'b1, y, c1, c2, 8'(r), 9'(g), 9'(b), ti);
  endtask

  task automatic idle_drain;
    drive(1'b0, 2'd0, 1'b0, '0, '0, '0, '0, '0, '0, "R3 idle");
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R2 drain: pending=%0d expected=0", expq.size());
      expq.delete();
    end
  endtask

  task automatic check_low(input string tag);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: out_valid=%b expected=0", tag, out_valid);
    end
  endtask

  // output monitor: compares the entry due this cycle
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (expq.size() > 0 && expq[0].issue + 2 == cyc) begin
        e = expq.pop_front();
        checks++;
        if (e.vld) begin
          if (out_valid !== 1'b1 || out_c0 !== e.e0 || out_c1 !== e.e1 || out_c2 !== e.e2) begin
            fails++;
            $display("FAIL %s: actual v=%b %h/%h/%h expected v=1 %h/%h/%h",
                     e.tag, out_valid, out_c0, out_c1, out_c2, e.e0, e.e1, e.e2);
          end
        end else if (out_valid !== 1'b0) begin
          fails++;
          $display("FAIL %s: out_valid=%b expected=0", e.tag, out_valid);
        end
      end else if (out_valid === 1'b1) begin
        checks++;
        fails++;
        $display("FAIL R2 unexpected output: out_valid=1 expected=0 at cycle %0d", cyc);
      end
    end
  end

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check_low("R1 during reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_low("R1 after reset");
    // pixel in flight is dropped by a reset
    drive(1'b1, 2'd0, 1'b0, 8'd1, 9'd2, 9'd3, '0, '0, '0, "R1 flush");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    expq.delete();
    @(negedge clk);
    check_low("R1 flush");
    @(negedge clk);
    check_low("R1 flush");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_low("R1 after flush");
  endtask

  task automatic t_diff;
    // R4 wrap: R=0 G=255 B=0 -> Y=255 Cb=1 Cr=1
    drive(1'b1, 2'd0, 1'b0, 8'd0, 9'd255, 9'd0, 8'd255, 9'd1, 9'd1, "R4 wrap");
    // R5 wrap: Y=200 Cb=100 Cr=0 -> R=200 G=200 B=44
    drive(1'b1, 2'd0, 1'b1, 8'd200, 9'd100, 9'd0, 8'd200, 9'd200, 9'd44, "R5 wrap");
    round_trip(0, 0, 0, 0, "R4 corner", "R5 corner");
    round_trip(0, 255, 0, 255, "R4 corner", "R5 corner");
    round_trip(0, 0, 255, 0, "R4 corner", "R5 corner");
    round_trip(0, 255, 255, 255, "R4 corner", "R5 corner");
    idle_drain();
  endtask

  task automatic t_rct;
    // R6: R=10 G=20 B=30 -> Y=20 Cb=10 Cr=-10
    drive(1'b1, 2'd1, 1'b0, 8'd10, 9'd20, 9'd30, 8'd20, 9'd10, 9'h1F6, "R6 value");
    // R7 floor of a negative sum: Y=0 Cb=-1 Cr=-1 -> R=0 G=1 B=0
    drive(1'b1, 2'd1, 1'b1, 8'd0, 9'h1FF, 9'h1FF, 8'd0, 9'd1, 9'd0, "R7 floor");
    round_trip(1, 255, 0, 255, "R6 corner", "R7 corner");
    round_trip(1, 0, 255, 0, "R6 corner", "R7 corner");
    round_trip(1, 255, 0, 0, "R6 corner", "R7 corner");
    round_trip(1, 0, 0, 255, "R6 corner", "R7 corner");
    round_trip(1, 1, 254, 3, "R6 corner", "R7 corner");
    idle_drain();
  endtask

  task automatic t_lift;
    // R8: R=30 G=0 B=10 -> Co=-20 t=20 Cg=20 Y=10
    drive(1'b1, 2'd2, 1'b0, 8'd30, 9'd0, 9'd10, 8'd10, 9'h1EC, 9'd20, "R8 value");
    // R9: Y=10 Co=-20 Cg=20 -> R=30 G=0 B=10
    drive(1'b1, 2'd2, 1'b1, 8'd10, 9'h1EC, 9'd20, 8'd30, 9'd0, 9'd10, "R9 value");
    round_trip(2, 255, 0, 0, "R8 corner", "R9 corner");
    round_trip(2, 0, 0, 255, "R8 corner", "R9 corner");
    round_trip(2, 0, 255, 0, "R8 corner", "R9 corner");
    round_trip(2, 255, 255, 255, "R8 corner", "R9 corner");
    round_trip(2, 1, 0, 0, "R8 corner", "R9 corner");
    idle_drain();
  endtask

  task automatic t_spare;
    // R10: R=5 G=10 B=3 -> Y=10 Cb=249 Cr=251, same as mode 0
    drive(1'b1, 2'd3, 1'b0, 8'd5, 9'd10, 9'd3, 8'd10, 9'h0F9, 9'h0FB, "R10 forward");
    drive(1'b1, 2'd3, 1'b1, 8'd10, 9'h0F9, 9'h0FB, 8'd5, 9'd10, 9'd3, "R10 inverse");
    idle_drain();
  endtask

  task automatic t_top_bits;
    logic [7:0] y;
    logic [8:0] c1, c2;
    for (int m = 0; m < 3; m++) begin
      model(m, 77, 140, 9, y, c1, c2);
      drive(1'b1, 2'(m), 1'b0, 8'd77, {1'b1, 8'd140}, {1'b1, 8'd9}, y, c1, c2, "R11 forward");
    end
    // mode 0 inverse with bit 8 set: Y=40 Cb=20 Cr=30 -> R=70 G=40 B=60
    drive(1'b1, 2'd0, 1'b1, 8'd40, 9'h114, 9'h11E, 8'd70, 9'd40, 9'd60, "R11 inverse");
    idle_drain();
  endtask

  task automatic t_mixed;
    for (int i = 0; i < 48; i++) begin
      round_trip(i % 3, (i * 37) % 256, (i * 91 + 13) % 256, (i * 53 + 200) % 256,
                 "R2 mixed forward", "R2 mixed inverse");
    end
    idle_drain();
  endtask

  task automatic t_bubbles;
    for (int i = 0; i < 16; i++) begin
      round_trip(i % 3, (i * 16) % 256, 255 - i, (i * 29) % 256, "R3 fwd", "R3 inv");
      bubble(8'(i * 73 + 5));
    end
    idle_drain();
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 256; r += 15)
        for (int g = 0; g < 256; g += 15)
          for (int b = 0; b < 256; b += 15)
            round_trip(m, r, g, b,
                       (m == 0) ? "R4 sweep" : (m == 1) ? "R6 sweep" : "R8 sweep",
                       (m == 0) ? "R5 sweep" : (m == 1) ? "R7 sweep" : "R9 sweep");
      idle_drain();
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_diff();
    t_rct();
    t_lift();
    t_spare();
    t_top_bits();
    t_mixed();
    t_bubbles();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule